// File: doc/BRIEF.md
# Dual-Role Buffered SPI Port

This block is a full-duplex serial port that works either as bus master or as bus slave. A single control bit picks the role. Software talks to it through a small write port and a receive pop strobe. Each direction has one software-visible buffer in front of a hidden shift register. A queued transmit byte moves into the shifter on its own, which frees the buffer for the next byte. A received byte is copied out of its shifter into the receive buffer as soon as its last bit arrives.

As master, the port makes the serial clock from the system clock through a 16-bit divider. It drives a byte on MOSI and samples MISO at the same time. The select lines for external slaves come from a software-written register whose bits go straight to output pins. As slave, the port follows an external clock and an active-low select input. Both pass through a two-stage synchroniser. It captures MOSI and drives MISO. Clock polarity and clock phase are configurable and apply in both roles. Bytes are 8 bits, most significant bit first.

Register writes use `cfg_addr`:
- 0: control
- 1: clock divider
- 2: transmit byte
- 3: select outputs

Top module: `spi_port`

## Requirements
- R1: After reset the status outputs are as follows: `tx_empty`=1, `rx_full`=0, `rx_ovf`=0, `tx_unf`=0 and `busy`=0. In addition, `sclk_o`=0 and every bit of `sel_n_o` is 1.
- R2: In master mode each half period of `sclk_o` lasts exactly N+1 system clocks, where N is the value written at address 1. A byte produces exactly 16 clock edges. Between transfers `sclk_o` rests at the polarity bit.
- R3: Control word at address 0: bit 0 = master, bit 1 = clock polarity, bit 2 = clock phase, bit 3 = clear the sticky flags (self-clearing). MOSI carries the byte MSB first. With phase 0 the first edge of each bit is the sampling edge; with phase 1 the second edge is.
- R4: If a byte is written at address 2 while the previous byte is still shifting, it follows with no gap. The clock runs 32 edges at a steady rate and `busy` stays high for 32(N+1) cycles. `tx_empty` returns to 1 as soon as a byte moves into the shifter.
- R5: A finished received byte appears on `rx_data` with `rx_full`=1. A pulse on `rx_rd` clears `rx_full`.
- R6: If a byte completes while `rx_full`=1, the sticky flag `rx_ovf` is set and `rx_data` keeps the older byte. Writing control bit 3 clears `rx_ovf`.
- R7: In master mode with the transmit buffer empty, no transfer starts. `busy` stays 0, `sclk_o` does not move, and `tx_unf` is not set.
- R8: In slave mode, while `ss_n_i` is low, the port shifts in MOSI and shifts out the queued byte on MISO, MSB first, for either phase.
- R9: If the slave is selected with an empty transmit buffer, `tx_unf` is set and the last byte sent is repeated on MISO. A frame that ends at the end of a byte does not set `tx_unf`.
- R10: Raising `ss_n_i` in the middle of a byte drops the partial byte, leaving `rx_full` unchanged. The next frame is received correctly from its first bit.
- R11: The low N_SEL bits written at address 3 appear on `sel_n_o` from the next cycle.
- R12: In slave mode, edges on `sclk_i` while `ss_n_i` is high have no effect. `busy` and `rx_full` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | DIV_W | Write data |
| rx_rd | input | 1 | Pop the receive buffer |
| rx_data | output | WORD | Receive buffer |
| tx_empty | output | 1 | Transmit buffer is free |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_unf | output | 1 | Sticky slave transmit underflow |
| busy | output | 1 | A byte or frame is in progress |
| sclk_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master serial data out |
| miso_i | input | 1 | Master serial data in |
| sclk_i | input | 1 | Slave serial clock |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |
| ss_n_i | input | 1 | Slave select, active low |
| sel_n_o | output | N_SEL | Programmable slave-select outputs |

## Verification
The assertions assume the following about the inputs:
- The role, polarity, phase and divider are not rewritten while `busy` is high.
- In slave mode, every level on `sclk_i`, `mosi_i` and `ss_n_i` lasts several system clocks, so the synchroniser sees each edge.

The stimulus reconfigures only while idle. It holds each external slave-clock level for eight system clocks. It also drops select about eight clocks before the first edge, so the first bit is already on MISO by then.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DIV  = 2'd1,
    REG_TX   = 2'd2,
    REG_SEL  = 2'd3
  } spi_reg_e;

  typedef struct packed {
    logic cpha;
    logic cpol;
    logic master;
  } spi_mode_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick && div != '0) |=> !tick);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int WORD  = 8,
  parameter int DIV_W = 16,
  parameter int N_SEL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [DIV_W-1:0] cfg_wdata,
  input  logic             rx_rd,
  output logic [WORD-1:0]  rx_data,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             rx_ovf,
  output logic             tx_unf,
  output logic             busy,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  input  logic             sclk_i,
  input  logic             mosi_i,
  output logic             miso_o,
  input  logic             ss_n_i,
  output logic [N_SEL-1:0] sel_n_o
);
  localparam int CNT_W = $clog2(WORD + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(WORD);

  spi_mode_t        mode_q;
  logic [DIV_W-1:0] div_q;
  logic [N_SEL-1:0] sel_q;
  logic [WORD-1:0]  tx_buf, last_tx, tsr, rsr, rx_buf, load_word, word_rx;
  logic             tx_full, out_r, sclk_r, unf_pend;
  logic [CNT_W-1:0] bit_cnt;
  logic             s_ss, s_sclk, s_mosi, sclk_d, tick;
  logic             m_run, lead, trail, sample, shift, din, s_edge;
  logic             word_done, word_end, start_m, start_s, abort_s;
  logic             reload, load, stop_m, clr_flags, tx_wr;

  spi_sync #(.W(3), .INIT(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({ss_n_i, sclk_i, mosi_i}),
    .q({s_ss, s_sclk, s_mosi})
  );

  spi_baud #(.W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(m_run), .div(div_q), .tick(tick)
  );

  always_comb begin
    clr_flags = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[3];
    tx_wr     = cfg_we && (cfg_addr == REG_TX);
    m_run     = busy && mode_q.master;
    s_edge    = busy && !mode_q.master && !s_ss && (s_sclk != sclk_d);
    if (mode_q.master) begin
      lead  = tick && (sclk_r == mode_q.cpol);
      trail = tick && (sclk_r != mode_q.cpol);
      din   = miso_i;
    end else begin
      lead  = s_edge && (s_sclk != mode_q.cpol);
      trail = s_edge && (s_sclk == mode_q.cpol);
      din   = s_mosi;
    end
    sample    = mode_q.cpha ? trail : lead;
    shift     = mode_q.cpha ? lead  : trail;
    word_rx   = {rsr[WORD-2:0], din};
    word_done = sample && (bit_cnt == LAST_BIT);
    word_end  = mode_q.cpha ? word_done : (trail && bit_cnt == ALL_BITS);
    start_m   = mode_q.master && !busy && tx_full;
    start_s   = !mode_q.master && !busy && !s_ss;
    abort_s   = !mode_q.master && busy && s_ss;
    reload    = word_end && (tx_full || !mode_q.master);
    load      = start_m || start_s || reload;
    stop_m    = word_end && mode_q.master && !tx_full;
    load_word = tx_full ? tx_buf : last_tx;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      div_q  <= '0;
      sel_q  <= '1;
      tx_buf <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_CTRL: mode_q <= '{cpha: cfg_wdata[2], cpol: cfg_wdata[1], master: cfg_wdata[0]};
        REG_DIV:  div_q  <= cfg_wdata;
        REG_TX:   tx_buf <= cfg_wdata[WORD-1:0];
        default:  sel_q  <= cfg_wdata[N_SEL-1:0];
      endcase
    end
  end

  // transfer engine
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; bit_cnt <= '0; sclk_r <= 1'b0; sclk_d <= 1'b0;
      tsr <= '0; out_r <= 1'b0; last_tx <= '0; tx_full <= 1'b0;
      rsr <= '0; rx_buf <= '0; rx_full <= 1'b0; rx_ovf <= 1'b0;
      tx_unf <= 1'b0; unf_pend <= 1'b0;
    end else begin
      sclk_d <= s_sclk;

      if (start_m || start_s)      busy <= 1'b1;
      else if (abort_s || stop_m)  busy <= 1'b0;

      if (start_m || start_s || abort_s || word_end) bit_cnt <= '0;
      else if (sample)                               bit_cnt <= bit_cnt + 1'b1;

      if (m_run) begin
        if (tick) sclk_r <= ~sclk_r;
      end else begin
        sclk_r <= mode_q.cpol;
      end

      if (load) begin
        last_tx <= load_word;
        if (mode_q.cpha) begin
          tsr <= load_word;
        end else begin
          out_r <= load_word[WORD-1];
          tsr   <= load_word << 1;
        end
      end else if (shift) begin
        out_r <= tsr[WORD-1];
        tsr   <= tsr << 1;
      end

      if (tx_wr)                tx_full <= 1'b1;
      else if (load && tx_full) tx_full <= 1'b0;

      if (reload && !tx_full && !mode_q.master) unf_pend <= 1'b1;
      else if (lead || !busy || abort_s)         unf_pend <= 1'b0;

      if ((start_s && !tx_full) || (unf_pend && lead)) tx_unf <= 1'b1;
      else if (clr_flags)                              tx_unf <= 1'b0;

      if (sample) rsr <= word_rx;

      if (word_done && (!rx_full || rx_rd)) begin
        rx_buf  <= word_rx;
        rx_full <= 1'b1;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end

      if (word_done && rx_full && !rx_rd) rx_ovf <= 1'b1;
      else if (clr_flags)                 rx_ovf <= 1'b0;
    end
  end

  assign rx_data  = rx_buf;
  assign tx_empty = !tx_full;
  assign sclk_o   = sclk_r;
  assign mosi_o   = out_r;
  assign miso_o   = out_r;
  assign sel_n_o  = sel_q;

  // R2
  sclk_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (m_run && !tick && !cfg_we) |=> $stable(sclk_r));
  // R6
  rx_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rx_rd) |=> $stable(rx_buf));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ovf && !clr_flags) |=> rx_ovf);
  // R7
  master_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q.master && !tx_full && !busy && !cfg_we) |=> !busy);
  // R10
  slave_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q.master && s_ss && !cfg_we) |=> !busy);
  // R8
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= ALL_BITS);
endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic tx_empty, rx_full, rx_ovf, tx_unf, busy, sclk_o, mosi_o, miso_o;
  logic miso_i;
  logic sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic [3:0] sel_n_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  // master-mode monitor
  logic mon_en = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0, sclk_prev = 1'b0;
  int mon_div = 0, edges = 0, gap_bad = 0, last_edge = 0, busy_cyc = 0;
  logic [7:0] cap = '0;

  always #4 clk = ~clk;
  assign miso_i = ~mosi_o;

  spi_port i_spi_port (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_rd(rx_rd), .rx_data(rx_data),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf), .tx_unf(tx_unf),
    .busy(busy), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .sclk_i(sclk_i), .mosi_i(mosi_i), .miso_o(miso_o), .ss_n_i(ss_n_i),
    .sel_n_o(sel_n_o)
  );

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (busy) busy_cyc++;
      if (sclk_o !== sclk_prev) begin
        edges++;
        if (edges > 1 && (cyc - last_edge) != mon_div + 1) gap_bad++;
        last_edge = cyc;
        if (mon_cpha ? (sclk_o == mon_cpol) : (sclk_o != mon_cpol))
          cap = {cap[6:0], mosi_o};
      end
      sclk_prev = sclk_o;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_busy(input logic v);
    while (busy !== v) @(negedge clk);
  endtask

  task automatic mon_start(input logic cpol, input logic cpha, input int div);
    repeat (3) @(negedge clk);
    mon_cpol = cpol; mon_cpha = cpha; mon_div = div;
    edges = 0; gap_bad = 0; busy_cyc = 0; cap = '0;
    sclk_prev = sclk_o;
    mon_en = 1'b1;
  endtask

  task automatic t_reset();
    check(tx_empty == 1 && rx_full == 0 && busy == 0, "R1 status",
          {tx_empty, rx_full, busy}, 3'b100);
    check(rx_ovf == 0 && tx_unf == 0, "R1 flags", {rx_ovf, tx_unf}, 0);
    check(sclk_o == 0 && sel_n_o == 4'hF, "R1 pins", {sclk_o, sel_n_o}, 5'h0F);
  endtask

  task automatic t_sel();
    wr(2'd3, 16'h0006);
    check(sel_n_o == 4'h6, "R11 select outputs", sel_n_o, 6);
  endtask

  task automatic t_master(input logic [7:0] tx, input logic cpol, input logic cpha, input int div);
    logic [7:0] inv;
    inv = ~tx;
    wr(2'd0, {13'd0, cpha, cpol, 1'b1});
    wr(2'd1, 16'(div));
    mon_start(cpol, cpha, div);
    check(sclk_o == cpol, "R2 idle level", sclk_o, cpol);
    wr(2'd2, {8'd0, tx});
    wait_busy(1'b1);
    wait_busy(1'b0);
    repeat (2) @(negedge clk);
    mon_en = 1'b0;
    check(edges == 16, "R2 edge count", edges, 16);
    check(gap_bad == 0, "R2 half period", gap_bad, 0);
    check(cap == tx, "R3 mosi bits", cap, tx);
    check(rx_full == 1 && rx_data == inv, "R5 receive", rx_data, inv);
    pop();
    check(rx_full == 0, "R5 pop", rx_full, 0);
  endtask

  task automatic t_b2b();
    logic [7:0] inv;
    inv = ~8'h6D;
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd1);
    mon_start(1'b0, 1'b0, 1);
    wr(2'd2, 16'h006D);
    wait_busy(1'b1);
    check(tx_empty == 1, "R4 handoff", tx_empty, 1);
    wr(2'd2, 16'h00B2);
    wait_busy(1'b0);
    repeat (2) @(negedge clk);
    mon_en = 1'b0;
    check(edges == 32 && gap_bad == 0, "R4 continuous clock", edges, 32);
    check(busy_cyc == 64, "R4 busy length", busy_cyc, 64);
    check(cap == 8'hB2, "R4 second byte", cap, 8'hB2);
    check(rx_ovf == 1, "R6 overflow set", rx_ovf, 1);
    check(rx_data == inv, "R6 old byte kept", rx_data, inv);
    wr(2'd0, 16'h0009);
    check(rx_ovf == 0, "R6 overflow clear", rx_ovf, 0);
    pop();
  endtask

  task automatic t_hold();
    logic moved;
    moved = 1'b0;
    wr(2'd0, 16'h0003);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk_o != 1'b1 || busy) moved = 1'b1;
    end
    check(!moved, "R7 no transfer", moved, 0);
    check(tx_unf == 0, "R7 no underflow", tx_unf, 0);
  endtask

  task automatic slave_frame(input logic [7:0] mo, input logic cpol, input logic cpha,
                             input int nbits, output logic [7:0] mi);
    mi = '0;
    sclk_i = cpol;
    @(negedge clk); ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        mosi_i = mo[7-i];
        repeat (8) @(negedge clk);
        sclk_i = ~cpol; mi = {mi[6:0], miso_o};
        repeat (8) @(negedge clk);
        sclk_i = cpol;
      end else begin
        sclk_i = ~cpol; mosi_i = mo[7-i];
        repeat (8) @(negedge clk);
        sclk_i = cpol; mi = {mi[6:0], miso_o};
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_slave(input logic [7:0] tx, input logic [7:0] mo, input logic cpol, input logic cpha);
    logic [7:0] mi;
    wr(2'd0, {13'd0, cpha, cpol, 1'b0});
    wr(2'd2, {8'd0, tx});
    slave_frame(mo, cpol, cpha, 8, mi);
    check(mi == tx, "R8 miso bits", mi, tx);
    check(rx_full == 1 && rx_data == mo, "R8 mosi capture", rx_data, mo);
    pop();
  endtask

  task automatic t_unf();
    logic [7:0] mi;
    wr(2'd0, 16'h000C);
    wr(2'd2, 16'h009D);
    slave_frame(8'h11, 1'b0, 1'b1, 8, mi);
    check(tx_unf == 0, "R9 no false underflow", tx_unf, 0);
    pop();
    slave_frame(8'h22, 1'b0, 1'b1, 8, mi);
    check(tx_unf == 1, "R9 underflow flag", tx_unf, 1);
    check(mi == 8'h9D, "R9 repeat last byte", mi, 8'h9D);
    check(rx_data == 8'h22, "R9 receive still works", rx_data, 8'h22);
    pop();
    wr(2'd0, 16'h0008);
  endtask

  task automatic t_abort();
    logic [7:0] mi;
    wr(2'd0, 16'h0000);
    slave_frame(8'hFF, 1'b0, 1'b0, 3, mi);
    check(rx_full == 0 && busy == 0, "R10 partial dropped", {rx_full, busy}, 0);
    slave_frame(8'h4B, 1'b0, 1'b0, 8, mi);
    check(rx_full == 1 && rx_data == 8'h4B, "R10 next frame", rx_data, 8'h4B);
    pop();
  endtask

  task automatic t_ignore();
    ss_n_i = 1'b1; mosi_i = 1'b1;
    for (int i = 0; i < 16; i++) begin
      repeat (8) @(negedge clk);
      sclk_i = ~sclk_i;
    end
    repeat (8) @(negedge clk);
    check(rx_full == 0 && busy == 0, "R12 unselected clock", {rx_full, busy}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sel();
    t_master(8'hA5, 1'b0, 1'b0, 3);
    t_master(8'h3C, 1'b1, 1'b1, 0);
    t_master(8'h81, 1'b0, 1'b1, 2);
    t_master(8'h5E, 1'b1, 1'b0, 1);
    t_b2b();
    t_hold();
    t_slave(8'hC3, 8'h96, 1'b0, 1'b0);
    t_slave(8'h5A, 8'h71, 1'b1, 1'b1);
    t_unf();
    t_abort();
    t_ignore();
    summary();
    $finish;
  end
endmodule